// File: doc/BRIEF.md
# SDRAM Single-Bank Read Sequencer

This block drives the command and address pins of a double-data-rate SDRAM for one read access at a time. A request carries a bank, a row, a column and a precharge-scope flag. The block opens the row, reads one burst of four words from the column without auto precharge, closes the row again, and then holds off the next open until the row-cycle and precharge intervals have run out. In every other cycle the command bus carries a no-operation.

Each minimum interval (row-to-column delay, active time, precharge time, row cycle time) has its own down-counter, loaded when the command that starts it goes out on the bus. One more counter keeps the close at least two cycles behind the read, so the burst is not cut off. The physical layer hands over the read data as two words per controller clock. The block serialises the four words into one word per cycle, each marked by a valid strobe.

Top module: `sdram_rd_seq`

## Requirements
- R1: `cmd_o` is `{ras_n, cas_n, we_n}`, with NOP=3'b111, ACTIVATE=3'b011, READ=3'b101 and PRECHARGE=3'b010. Any cycle without one of the three commands carries NOP. After reset `cmd_o` is NOP, `req_ready_o` is 1 and `rd_valid_o` is 0.
- R2: A request is taken in a cycle where `req_valid_i` and `req_ready_o` are both high. ACTIVATE appears in the next cycle, with `addr_o` equal to the row (zero-extended) and `ba_o` equal to the bank. `req_ready_o` stays low from acceptance until the next ACTIVATE is allowed.
- R3: READ appears exactly T_RCD cycles after ACTIVATE. `ba_o` carries the bank. `addr_o` carries the column zero-extended, with bit 10 low (auto precharge off).
- R4: PRECHARGE appears exactly max(T_RAS, T_RCD+2) cycles after ACTIVATE.
- R5: At PRECHARGE, `addr_o` bit 10 equals the request's scope flag and all other address bits are zero. When the flag is 0 (one bank), `ba_o` carries the request's bank.
- R6: An ACTIVATE that follows a PRECHARGE comes at least T_RP cycles after that PRECHARGE and at least T_RC cycles after the previous ACTIVATE. If a request is already waiting at PRECHARGE, the ACTIVATE comes at exactly the later of the two.
- R7: Let READ be on the bus in cycle r. `dq_i` in cycle r+CL holds word 0 (low half) and word 1 (high half). In cycle r+CL+1 it holds word 2 (low half) and word 3 (high half). `rd_data_o` shows words 0 to 3 in cycles r+CL+1 to r+CL+4, in that order.
- R8: `rd_valid_o` is high for exactly four cycles per request, only in the window given in R7, and bursts of different requests never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Read request offered |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_bank_i | input | BA_W | Bank of the request |
| req_row_i | input | ROW_W | Row of the request |
| req_col_i | input | COL_W | Starting column (COL_W <= 10) |
| req_all_i | input | 1 | Close all banks (1) or only the request's bank (0) |
| cmd_o | output | 3 | Command pins {ras_n, cas_n, we_n} |
| addr_o | output | ADDR_W | Address pins |
| ba_o | output | BA_W | Bank address pins |
| dq_i | input | 2*DQ_W | Captured data pair: low half first word, high half second |
| rd_valid_o | output | 1 | Read word valid |
| rd_data_o | output | DQ_W | Read word |

## Verification
Single requests separated by idle time show that acceptance leads straight to ACTIVATE and that the read-to-close spacing follows the counters alone. Requests held back-to-back with valid continuously high expose the reopen gap: there the row-cycle counter must dominate the precharge counter. Both scope settings are tried with different banks, so a swapped or missing bit 10 and a wrong bank at close are visible. Row and column extremes (zero, all ones) are used, and the data model derives every word from the address it sees on the bus. Any address slip, beat swap or capture one cycle early or late therefore shows up as a data mismatch.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_READ
  } seq_st_e;
endpackage

// File: rtl/sdram_rd_timer.sv
module sdram_rd_timer #(
  parameter int unsigned LIMIT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LOAD_VAL = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int unsigned DQ_W = 8,
  parameter int unsigned CL   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_issue_i,
  input  logic [2*DQ_W-1:0] dq_i,
  output logic              rd_valid_o,
  output logic [DQ_W-1:0]   rd_data_o
);
  localparam int unsigned SR_W = CL + 2;

  logic [SR_W-1:0] sr_q;
  logic [DQ_W-1:0] hold_q [2];
  logic [1:0]      rem_q;
  logic            pair0, pair1;

  // sr_q[i] is set i cycles after the READ is on the bus
  assign pair0 = sr_q[CL];
  assign pair1 = sr_q[CL+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      hold_q[0]  <= '0;
      hold_q[1]  <= '0;
      rem_q      <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      sr_q <= {sr_q[SR_W-2:0], rd_issue_i};
      if (pair0) begin
        rd_data_o  <= dq_i[DQ_W-1:0];
        rd_valid_o <= 1'b1;
        hold_q[0]  <= dq_i[2*DQ_W-1:DQ_W];
        rem_q      <= 2'd3;
      end else if (rem_q != 2'd0) begin
        rd_data_o  <= hold_q[0];
        rd_valid_o <= 1'b1;
        rem_q      <= rem_q - 2'd1;
        if (pair1) begin
          hold_q[0] <= dq_i[DQ_W-1:0];
          hold_q[1] <= dq_i[2*DQ_W-1:DQ_W];
        end else begin
          hold_q[0] <= hold_q[1];
        end
      end else begin
        rd_valid_o <= 1'b0;
      end
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair0 |-> (rem_q == 2'd0)); // R8
  AST_SECOND_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair1 |-> (rem_q == 2'd3 && rd_valid_o)); // R7
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DQ_W   = 8,
  parameter int unsigned T_RCD  = 3,
  parameter int unsigned T_RAS  = 7,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_RC   = 12,
  parameter int unsigned CL     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BA_W-1:0]   req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_all_i,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  input  logic [2*DQ_W-1:0] dq_i,
  output logic              rd_valid_o,
  output logic [DQ_W-1:0]   rd_data_o
);
  localparam int unsigned AP_BIT    = 10;
  localparam int unsigned BURST_CYC = 2; // four words, two per clock

  seq_st_e             st_q, st_d;
  cmd_e                cmd_q, cmd_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [BA_W-1:0]     ba_q, ba_d;
  logic [BA_W-1:0]     bank_q;
  logic [COL_W-1:0]    col_q;
  logic                all_q;
  logic                accept;
  logic                rcd_done, ras_done, rp_done, rc_done, rtp_done;
  logic                is_act, is_rd, is_pre;

  assign req_ready_o = (st_q == ST_IDLE) && rp_done && rc_done;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    st_d   = st_q;
    cmd_d  = CMD_NOP;
    addr_d = '0;
    ba_d   = bank_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        cmd_d              = CMD_ACT;
        addr_d[ROW_W-1:0]  = req_row_i;
        ba_d               = req_bank_i;
        st_d               = ST_OPEN;
      end
      ST_OPEN: if (rcd_done) begin
        cmd_d              = CMD_RD;
        addr_d[COL_W-1:0]  = col_q;
        addr_d[AP_BIT]     = 1'b0;
        st_d               = ST_READ;
      end
      ST_READ: if (ras_done && rtp_done) begin
        cmd_d              = CMD_PRE;
        addr_d[AP_BIT]     = all_q;
        st_d               = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      bank_q <= '0;
      col_q  <= '0;
      all_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      ba_q   <= ba_d;
      if (accept) begin
        bank_q <= req_bank_i;
        col_q  <= req_col_i;
        all_q  <= req_all_i;
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign addr_o = addr_q;
  assign ba_o   = ba_q;

  assign is_act = (cmd_d == CMD_ACT);
  assign is_rd  = (cmd_d == CMD_RD);
  assign is_pre = (cmd_d == CMD_PRE);

  sdram_rd_timer #(.LIMIT(T_RCD)) u_trcd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_act), .done_o(rcd_done));
  sdram_rd_timer #(.LIMIT(T_RAS)) u_tras (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_act), .done_o(ras_done));
  sdram_rd_timer #(.LIMIT(T_RC)) u_trc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_act), .done_o(rc_done));
  sdram_rd_timer #(.LIMIT(T_RP)) u_trp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_pre), .done_o(rp_done));
  // keeps the close behind the last data beat
  sdram_rd_timer #(.LIMIT(BURST_CYC)) u_trtp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_rd), .done_o(rtp_done));

  sdram_rd_capture #(.DQ_W(DQ_W), .CL(CL)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_issue_i (is_rd),
    .dq_i       (dq_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  AST_ACCEPT_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (cmd_o == CMD_ACT)); // R2
  AST_RD_AFTER_RCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD) |-> ($past(rcd_done) && !addr_o[AP_BIT])); // R3
  AST_PRE_AFTER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE) |-> $past(ras_done && rtp_done)); // R4
  AST_ACT_AFTER_RP_RC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |-> $past(rp_done && rc_done)); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT || cmd_o == CMD_RD) |-> !req_ready_o); // R2
endmodule

// File: tb/sdram_rd_seq_test.sv
module sdram_rd_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int BA_W = 2, ROW_W = 13, COL_W = 10, ADDR_W = 13, DQ_W = 8;
  localparam int T_RCD = 3, T_RAS = 7, T_RP = 3, T_RC = 12, CL = 2;
  localparam int PRE_GAP = (T_RAS > T_RCD + 2) ? T_RAS : T_RCD + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_all = 1'b0;
  logic [BA_W-1:0] req_bank = '0, ba;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [2:0] cmd;
  logic [ADDR_W-1:0] addr;
  logic [2*DQ_W-1:0] dq = '0;
  logic rd_valid;
  logic [DQ_W-1:0] rd_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  logic [DQ_W-1:0] exp_q[$];

  sdram_rd_seq #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DQ_W(DQ_W),
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC), .CL(CL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_all_i(req_all),
    .cmd_o(cmd), .addr_o(addr), .ba_o(ba), .dq_i(dq),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DQ_W-1:0] wfun(input int row, input int col, input int beat);
    return DQ_W'(row * 7 + col * 3 + beat * 61 + 5);
  endfunction

  // memory model and command-bus monitor
  int acc_cyc = -100, last_act = -100, last_pre = -100, rd_cyc = -100;
  bit have_pre = 0, pend_at_pre = 0;
  int a_row = 0, a_col = 0, a_bank = 0, m_row = 0, m_col = 0;
  bit a_all = 0;

  always @(negedge clk) if (rst_n) begin
    int exp_act;
    bit exp_v;
    chk(cmd == 3'b111 || cmd == 3'b011 || cmd == 3'b101 || cmd == 3'b010, "R1", cmd, 7);
    if (req_valid && req_ready) begin
      acc_cyc = cyc;
      a_row = req_row; a_col = req_col; a_bank = req_bank; a_all = req_all;
    end
    case (cmd)
      3'b011: begin
        chk(cyc == acc_cyc + 1, "R2", cyc, acc_cyc + 1);
        chk(addr == ADDR_W'(a_row) && ba == BA_W'(a_bank), "R2", addr, a_row);
        if (have_pre) begin
          chk(cyc - last_pre >= T_RP, "R6", cyc - last_pre, T_RP);
          chk(cyc - last_act >= T_RC, "R6", cyc - last_act, T_RC);
          if (pend_at_pre) begin
            exp_act = (last_pre + T_RP > last_act + T_RC) ? last_pre + T_RP : last_act + T_RC;
            chk(cyc == exp_act, "R6", cyc, exp_act);
          end
        end
        last_act = cyc;
        m_row = addr;
      end
      3'b101: begin
        chk(cyc - last_act == T_RCD, "R3", cyc - last_act, T_RCD);
        chk(addr == ADDR_W'(a_col) && !addr[10] && ba == BA_W'(a_bank), "R3", addr, a_col);
        rd_cyc = cyc;
        m_col = addr[COL_W-1:0];
      end
      3'b010: begin
        chk(cyc - last_act == PRE_GAP, "R4", cyc - last_act, PRE_GAP);
        chk(addr == (a_all ? ADDR_W'(1 << 10) : ADDR_W'(0)), "R5", addr, a_all ? 1024 : 0);
        if (!a_all) chk(ba == BA_W'(a_bank), "R5", ba, a_bank);
        last_pre = cyc; have_pre = 1; pend_at_pre = req_valid;
      end
      default: ;
    endcase
    if (cyc == rd_cyc + CL)
      dq = {wfun(m_row, m_col, 1), wfun(m_row, m_col, 0)};
    else if (cyc == rd_cyc + CL + 1)
      dq = {wfun(m_row, m_col, 3), wfun(m_row, m_col, 2)};
    else
      dq = 16'hA5C3;
    // output timing window and scoreboard
    exp_v = (cyc >= rd_cyc + CL + 1) && (cyc <= rd_cyc + CL + 4);
    if (exp_v || rd_valid) chk(rd_valid == exp_v, "R8", rd_valid, exp_v);
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R8", rd_data, -1);
      else begin
        logic [DQ_W-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R7", rd_data, e);
      end
    end
  end

  task automatic send_req(input int bank, input int row, input int col, input bit all);
    req_bank = BA_W'(bank); req_row = ROW_W'(row); req_col = COL_W'(col); req_all = all;
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    for (int b = 0; b < 4; b++) exp_q.push_back(wfun(row, col, b));
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd == 3'b111, "R1", cmd, 7);
    chk(rd_valid == 1'b0, "R1", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    idle(2);
    // single bank close, then idle gap
    send_req(1, 13'h0123, 10'h05, 0);
    idle(30);
    // close all banks
    send_req(2, 13'h1FFF, 10'h3FF, 1);
    idle(30);
    // back-to-back: reopen spacing bound by the row cycle counter
    send_req(3, 0, 0, 0);
    send_req(0, 13'h0AAA, 10'h155, 1);
    send_req(1, 13'h1555, 10'h2AA, 0);
    send_req(2, 13'h0042, 10'h001, 0);
    // late request after a long gap
    idle(50);
    send_req(0, 13'h0777, 10'h200, 1);
    idle(40);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
    chk(req_ready == 1'b1 && cmd == 3'b111, "R1", req_ready, 1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule